// File: doc/BRIEF.md
# Virtual-Memory ID Allocator with Address-Space Association

This block hands out hardware virtual-memory identifiers (VMIDs) to software processes named by an address-space identifier (PASID). An allocate request carries a PASID. One cycle later a response reports either the granted VMID or a failure. Identifier 0 is kept for the kernel context and is never granted. The search always starts at 1 and returns the lowest identifier that is not in use.

Each grant stores the requesting PASID in a slot owned by the granted VMID. This lets a later release name either the VMID or the PASID. A release by PASID searches every slot in parallel and frees each VMID whose live association matches. A release by VMID frees only the identifier and leaves the stored association alone, so a stale association stays until its slot is granted again. A clear input drops all grants and all associations in one cycle. The most recently granted VMID stays visible on its own output.

Top module: `vmid_alloc`

## Requirements
- R1: While reset is held and in the first cycle after it, `rsp_valid`, `rsp_ok` and `pasid_miss` are 0 and `last_vmid` is 0.
- R2: An accepted `alloc_req` raises `rsp_valid` exactly one cycle later. When an identifier is free, `rsp_ok` is 1 and `rsp_vmid` is the lowest free identifier in 1..NUM_IDS-1, which from then on counts as used.
- R3: `rsp_ok` is never 1 together with `rsp_vmid` equal to 0; identifier 0 is never granted.
- R4: When identifiers 1..NUM_IDS-1 are all used, an allocate returns `rsp_ok`=0 and `rsp_vmid`=0 and changes no state.
- R5: `free_vmid_req` makes the identifier on `free_vmid` free again and leaves every other identifier as it was.
- R6: `free_pasid_req` frees every identifier whose live association holds `free_pasid` and removes those associations; a second release of the same PASID then misses.
- R7: A `free_pasid_req` that matches no live association raises `pasid_miss` for exactly one cycle, in the cycle after the request, and frees nothing. Granting a slot to another PASID removes the association the slot held before.
- R8: `clear_all` frees every identifier and removes every association; the next allocate returns 1.
- R9: `last_vmid` changes only on a successful grant, where it equals `rsp_vmid`; failures, releases and clears leave it unchanged.
- R10: Only one operation is accepted per cycle, with priority `clear_all` > `free_pasid_req` > `free_vmid_req` > `alloc_req`. Lower-priority requests in the same cycle are dropped. A dropped allocate still gets `rsp_valid`, with `rsp_ok`=0.
- R11: A `free_vmid_req` naming identifier 0 or an identifier that is already free has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Allocate request |
| alloc_pasid | input | PASID_W | PASID to associate with the grant |
| free_vmid_req | input | 1 | Release by identifier |
| free_vmid | input | ID_W | Identifier to release |
| free_pasid_req | input | 1 | Release by PASID |
| free_pasid | input | PASID_W | PASID to release |
| clear_all | input | 1 | Drop all grants and associations |
| rsp_valid | output | 1 | Allocate response present |
| rsp_ok | output | 1 | Grant succeeded |
| rsp_vmid | output | ID_W | Granted identifier, 0 on failure |
| pasid_miss | output | 1 | Release by PASID found no association |
| last_vmid | output | ID_W | Most recently granted identifier |

## Verification
The hardest case to reach is a stale association. A slot freed by identifier still holds its old PASID, and that PASID must stop matching once the slot is granted to someone else. The bench fills every identifier, frees one by number, re-grants it under a new PASID, and then releases the old PASID, expecting a miss. It also grants two identifiers under one PASID and checks that a single release by PASID frees both, which it confirms through the order of later grants.

// File: rtl/vmid_pkg.sv
package vmid_pkg;
    localparam int DEF_NUM_IDS = 16;
    localparam int DEF_PASID_W = 16;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CLEAR,
        OP_FREE_PASID,
        OP_FREE_VMID,
        OP_ALLOC
    } vmid_op_e;

    // Fixed priority: clear > release by PASID > release by id > allocate
    function automatic vmid_op_e pick_op(input logic clr, input logic fp,
                                         input logic fv, input logic al);
        if (clr)     return OP_CLEAR;
        else if (fp) return OP_FREE_PASID;
        else if (fv) return OP_FREE_VMID;
        else if (al) return OP_ALLOC;
        else         return OP_NONE;
    endfunction
endpackage

// File: rtl/vmid_lowest_free.sv
module vmid_lowest_free #(
    parameter int NUM_IDS = 16,
    localparam int ID_W = $clog2(NUM_IDS)
) (
    input  logic [NUM_IDS-1:0] used,
    output logic               found,
    output logic [ID_W-1:0]    idx
);
    logic [NUM_IDS-1:0] avail;

    // Identifier 0 is reserved and never offered
    always_comb begin
        avail    = ~used;
        avail[0] = 1'b0;
    end

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_IDS - 1; i >= 1; i--) begin
            if (avail[i]) begin
                found = 1'b1;
                idx   = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/vmid_pasid_cam.sv
module vmid_pasid_cam #(
    parameter int NUM_IDS = 16,
    parameter int PASID_W = 16
) (
    input  logic [NUM_IDS-1:0]              live,
    input  logic [NUM_IDS-1:0][PASID_W-1:0] keys,
    input  logic [PASID_W-1:0]              probe,
    output logic [NUM_IDS-1:0]              hit
);
    for (genvar g = 0; g < NUM_IDS; g++) begin : g_cmp
        assign hit[g] = live[g] && (keys[g] == probe);
    end
endmodule

// File: rtl/vmid_alloc.sv
module vmid_alloc
    import vmid_pkg::*;
#(
    parameter int NUM_IDS = DEF_NUM_IDS,
    parameter int PASID_W = DEF_PASID_W,
    localparam int ID_W = $clog2(NUM_IDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               alloc_req,
    input  logic [PASID_W-1:0] alloc_pasid,
    input  logic               free_vmid_req,
    input  logic [ID_W-1:0]    free_vmid,
    input  logic               free_pasid_req,
    input  logic [PASID_W-1:0] free_pasid,
    input  logic               clear_all,
    output logic               rsp_valid,
    output logic               rsp_ok,
    output logic [ID_W-1:0]    rsp_vmid,
    output logic               pasid_miss,
    output logic [ID_W-1:0]    last_vmid
);
    logic [NUM_IDS-1:0]              used_q;
    logic [NUM_IDS-1:0]              assoc_q;
    logic [NUM_IDS-1:0][PASID_W-1:0] pasid_q;

    vmid_op_e           op;
    logic               have_free;
    logic [ID_W-1:0]    free_idx;
    logic [NUM_IDS-1:0] hit;
    logic               grant;

    assign op    = pick_op(clear_all, free_pasid_req, free_vmid_req, alloc_req);
    assign grant = (op == OP_ALLOC) && have_free;

    vmid_lowest_free #(.NUM_IDS(NUM_IDS)) u_pick (
        .used  (used_q),
        .found (have_free),
        .idx   (free_idx)
    );

    vmid_pasid_cam #(.NUM_IDS(NUM_IDS), .PASID_W(PASID_W)) u_cam (
        .live  (assoc_q),
        .keys  (pasid_q),
        .probe (free_pasid),
        .hit   (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            used_q     <= '0;
            assoc_q    <= '0;
            pasid_q    <= '0;
            rsp_valid  <= 1'b0;
            rsp_ok     <= 1'b0;
            rsp_vmid   <= '0;
            pasid_miss <= 1'b0;
            last_vmid  <= '0;
        end else begin
            rsp_valid  <= alloc_req;
            rsp_ok     <= grant;
            rsp_vmid   <= grant ? free_idx : '0;
            pasid_miss <= (op == OP_FREE_PASID) && (hit == '0);
            unique case (op)
                OP_CLEAR: begin
                    used_q  <= '0;
                    assoc_q <= '0;
                end
                OP_FREE_PASID: begin
                    used_q  <= used_q & ~hit;
                    assoc_q <= assoc_q & ~hit;
                end
                OP_FREE_VMID: begin
                    if (free_vmid != '0) used_q[free_vmid] <= 1'b0;
                end
                OP_ALLOC: begin
                    if (have_free) begin
                        used_q[free_idx]  <= 1'b1;
                        assoc_q[free_idx] <= 1'b1;
                        pasid_q[free_idx] <= alloc_pasid;
                        last_vmid         <= free_idx;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vmid_alloc_chk.sv
module vmid_alloc_chk #(
    parameter int ID_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            alloc_req,
    input logic            free_pasid_req,
    input logic            free_vmid_req,
    input logic            clear_all,
    input logic            rsp_valid,
    input logic            rsp_ok,
    input logic [ID_W-1:0] rsp_vmid,
    input logic            pasid_miss,
    input logic [ID_W-1:0] last_vmid
);
    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_req |=> rsp_valid);

    // R3
    no_zero_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ok) |-> (rsp_vmid != '0));

    // R9
    last_tracks_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ok) |-> (last_vmid == rsp_vmid));

    // R9
    last_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !(rsp_valid && rsp_ok) |-> $stable(last_vmid));

    // R7
    miss_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        pasid_miss |-> $past(free_pasid_req));

    // R10
    clear_drops_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        (clear_all && alloc_req) |=> !rsp_ok);

    // R8
    clear_then_one_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(clear_all) && alloc_req && !clear_all && !free_pasid_req && !free_vmid_req)
        |=> (rsp_ok && rsp_vmid == ID_W'(1)));
endmodule

bind vmid_alloc vmid_alloc_chk #(.ID_W(ID_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .alloc_req      (alloc_req),
    .free_pasid_req (free_pasid_req),
    .free_vmid_req  (free_vmid_req),
    .clear_all      (clear_all),
    .rsp_valid      (rsp_valid),
    .rsp_ok         (rsp_ok),
    .rsp_vmid       (rsp_vmid),
    .pasid_miss     (pasid_miss),
    .last_vmid      (last_vmid)
);

// File: tb/vmid_alloc_bench.sv
module vmid_alloc_bench;
    localparam int N  = 16;
    localparam int PW = 16;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          alloc_req = 1'b0;
    logic [PW-1:0] alloc_pasid = '0;
    logic          free_vmid_req = 1'b0;
    logic [IW-1:0] free_vmid = '0;
    logic          free_pasid_req = 1'b0;
    logic [PW-1:0] free_pasid = '0;
    logic          clear_all = 1'b0;
    logic          rsp_valid, rsp_ok, pasid_miss;
    logic [IW-1:0] rsp_vmid, last_vmid;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    vmid_alloc u_vmid_alloc (
        .clk(clk), .rst(rst),
        .alloc_req(alloc_req), .alloc_pasid(alloc_pasid),
        .free_vmid_req(free_vmid_req), .free_vmid(free_vmid),
        .free_pasid_req(free_pasid_req), .free_pasid(free_pasid),
        .clear_all(clear_all),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_vmid(rsp_vmid),
        .pasid_miss(pasid_miss), .last_vmid(last_vmid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one cycle with the given requests; outputs sampled at the next negedge
    task automatic step(input logic al, input int ap, input logic fv, input int fvi,
                        input logic fp, input int fpp, input logic clr);
        alloc_req = al;  alloc_pasid = PW'(ap);
        free_vmid_req = fv; free_vmid = IW'(fvi);
        free_pasid_req = fp; free_pasid = PW'(fpp);
        clear_all = clr;
        @(posedge clk);
        @(negedge clk);
        alloc_req = 0; free_vmid_req = 0; free_pasid_req = 0; clear_all = 0;
    endtask

    task automatic alloc(input string req, input int pasid, input int exp_ok, input int exp_id);
        step(1, pasid, 0, 0, 0, 0, 0);
        chk({req, " valid"}, int'(rsp_valid), 1);
        chk({req, " ok"}, int'(rsp_ok), exp_ok);
        chk({req, " vmid"}, int'(rsp_vmid), exp_id);
    endtask

    task automatic free_p(input string req, input int pasid, input int exp_miss);
        step(0, 0, 0, 0, 1, pasid, 0);
        chk({req, " miss"}, int'(pasid_miss), exp_miss);
    endtask

    task automatic clear();
        step(0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic t_reset();
        chk("R1 rsp_valid", int'(rsp_valid), 0);
        chk("R1 rsp_ok", int'(rsp_ok), 0);
        chk("R1 miss", int'(pasid_miss), 0);
        chk("R1 last", int'(last_vmid), 0);
    endtask

    task automatic t_fill();
        for (int i = 1; i < N; i++) alloc("R2 fill", 'h100 + i, 1, i);
        chk("R9 last after fill", int'(last_vmid), N - 1);
        alloc("R4 full", 'h200, 0, 0);
        chk("R9 last after fail", int'(last_vmid), N - 1);
        alloc("R4 still full", 'h201, 0, 0);
    endtask

    task automatic t_free_vmid();
        step(0, 0, 1, 0, 0, 0, 0);          // id 0: no effect
        alloc("R11 free zero", 'h300, 0, 0);
        step(0, 0, 1, 5, 0, 0, 0);
        chk("R9 last after free", int'(last_vmid), N - 1);
        alloc("R5 regrant 5", 'h205, 1, 5);
        alloc("R5 others kept", 'h206, 0, 0);
        step(0, 0, 1, 9, 0, 0, 0);
        step(0, 0, 1, 9, 0, 0, 0);          // already free: no effect
        alloc("R11 double free", 'h209, 1, 9);
        alloc("R11 nothing extra", 'h20a, 0, 0);
    endtask

    task automatic t_stale();
        free_p("R7 stale assoc", 'h105, 1);   // slot 5 re-granted to 0x205
        step(0, 0, 0, 0, 0, 0, 0);
        chk("R7 miss one cycle", int'(pasid_miss), 0);
        alloc("R7 nothing freed", 'h300, 0, 0);
        free_p("R6 free by pasid", 'h103, 0);
        alloc("R6 regrant 3", 'h303, 1, 3);
        free_p("R6 second release", 'h103, 1);
        free_p("R7 absent pasid", 'hbeef, 1);
    endtask

    task automatic t_multi();
        clear();
        chk("R9 last after clear", int'(last_vmid), 3);
        alloc("R8 after clear", 'h77, 1, 1);
        alloc("R6 dup pasid", 'h77, 1, 2);
        alloc("R6 other", 'h88, 1, 3);
        free_p("R6 multi release", 'h77, 0);
        alloc("R6 freed 1", 'h90, 1, 1);
        alloc("R6 freed 2", 'h91, 1, 2);
        alloc("R6 next 4", 'h92, 1, 4);
    endtask

    task automatic t_priority();
        step(1, 'h55, 0, 0, 0, 0, 1);        // clear beats alloc
        chk("R10 dropped valid", int'(rsp_valid), 1);
        chk("R10 dropped ok", int'(rsp_ok), 0);
        alloc("R10 clear won", 'h56, 1, 1);
        alloc("R10 setup", 'h57, 1, 2);
        step(0, 0, 1, 1, 1, 'h57, 0);        // pasid release beats id release
        chk("R10 no miss", int'(pasid_miss), 0);
        alloc("R10 pasid won", 'h58, 1, 2);
        alloc("R10 id1 kept", 'h59, 1, 3);
        step(1, 'h60, 1, 3, 0, 0, 0);        // id release beats alloc
        chk("R10 alloc dropped", int'(rsp_ok), 0);
        alloc("R10 id won", 'h61, 1, 3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst = 0;
        @(posedge clk);
        @(negedge clk);
        t_reset();
        t_fill();
        t_free_vmid();
        t_stale();
        t_multi();
        t_priority();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule